// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block is the register side of a mailbox that links two processors. A sending side (A) and a receiving side (B) share one 32-bit register bus. Through it they exchange a block of message words, ring a doorbell or answer with an acknowledge, and post single-word values on a set of fast channels. Each fast-channel write also raises an event for the other side.

All events collect in one shared interrupt status register. The status bits are cleared by writing ones. Each side owns a private enable mask, and the block drives one interrupt line per side from the status bits that side has enabled. Seven status bits are fed by event pulses from a separate FIFO channel block. An error-compare register pair collects sticky error flags from outside the bank and lets software clear them.

Top module: `mbox_bank`

## Requirements
- R1: After reset all message words, fast-channel words, both enable masks, the status register and the error register read as zero, and both interrupt lines are low.
- R2: Message word n (0 to MSG_WORDS-1) is at byte offset 4*n. It is written with the bus word and reads back what was last written.
- R3: A write to the trigger register at byte offset 0x80 sets status bit 0 when data bit 0 is 1 and sets status bit 1 when data bit 1 is 1. The trigger register always reads as zero.
- R4: A write to fast channel n (0 to FAST_CH-1) at byte offset 0x8C+4*n stores the word, which then reads back at that offset, and sets status bit 9+n.
- R5: Writing the clear register at 0xC4 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. The status register reads at 0xC8.
- R6: When a set event and a clear hit the same status or error bit in the same cycle, the bit ends up set.
- R7: A one-cycle pulse on fifo_evt[k] (k = 0 to 6) sets status bit 2+k. The bits are full 2, empty 3, watermark rising 4, watermark falling 5, overflow 6, underflow 7, non-empty 8.
- R8: The side-A mask at 0xBC and the side-B mask at 0xC0 are read/write, one bit per status bit. irq_a is high exactly when some status bit and its side-A mask bit are both 1. irq_b works the same way with the side-B mask.
- R9: A pulse on err_evt[k] sets bit k of the error register, which reads at 0x84 and ignores writes. Writing ones to 0x88 clears the matching bits, and 0x88 reads as zero.
- R10: Reads of unmapped word offsets return zero. Writes to unmapped offsets, and writes to the status register at 0xC8, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Bus access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| fifo_evt | input | 7 | Event pulses from the FIFO channel block |
| err_evt | input | ERR_W | Error flag pulses |
| irq_a | output | 1 | Interrupt to the sending side |
| irq_b | output | 1 | Interrupt to the receiving side |

## Verification
The bench builds the bank with its default values: 32 message words, 8 fast channels, a 16-bit error register and an 8-bit byte address. With these values the whole address map fits below 0x100, so the bench can reach the first and last message word, both ends of the fast-channel range, the gap reserved for the FIFO block and the offsets above the status register. It also reaches every status bit up to bit 16, which lets it check the two interrupt lines against all set sources.

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int MSG_WORDS = 32,
  parameter int FAST_CH   = 8,
  parameter int ERR_W     = 16,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [6:0]        fifo_evt,
  input  logic [ERR_W-1:0]  err_evt,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int ST_W = 9 + FAST_CH;
  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] A_TRIG   = WI_W'(MSG_WORDS);
  localparam logic [WI_W-1:0] A_ERR    = WI_W'(MSG_WORDS + 1);
  localparam logic [WI_W-1:0] A_ERRCLR = WI_W'(MSG_WORDS + 2);
  localparam int              W_FAST   = MSG_WORDS + 3;
  localparam logic [WI_W-1:0] A_ENA    = WI_W'(W_FAST + FAST_CH + 4);
  localparam logic [WI_W-1:0] A_ENB    = WI_W'(W_FAST + FAST_CH + 5);
  localparam logic [WI_W-1:0] A_CLR    = WI_W'(W_FAST + FAST_CH + 6);
  localparam logic [WI_W-1:0] A_STAT   = WI_W'(W_FAST + FAST_CH + 7);

  logic [WI_W-1:0]  widx;
  logic             wr_hit;
  logic [31:0]      msg_q  [MSG_WORDS];
  logic [31:0]      fast_q [FAST_CH];
  logic [FAST_CH-1:0] fast_hit;
  logic [ST_W-1:0]  st_q, st_set, st_clr, en_a_q, en_b_q;
  logic [ERR_W-1:0] err_q, err_clr;

  assign widx   = reg_addr[ADDR_W-1:2];
  assign wr_hit = reg_sel & reg_wr;

  genvar g;
  generate
    for (g = 0; g < FAST_CH; g++) begin : g_fast
      localparam logic [WI_W-1:0] A_CH = WI_W'(W_FAST + g);
      assign fast_hit[g] = wr_hit && (widx == A_CH);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)           fast_q[g] <= '0;
        else if (fast_hit[g]) fast_q[g] <= reg_wdata;
    end
    for (g = 0; g < MSG_WORDS; g++) begin : g_msg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              msg_q[g] <= '0;
        else if (wr_hit && widx == WI_W'(g))     msg_q[g] <= reg_wdata;
    end
  endgenerate

  wire trig_hit = wr_hit && (widx == A_TRIG);
  assign st_set = {fast_hit, fifo_evt,
                   trig_hit & reg_wdata[1], trig_hit & reg_wdata[0]};
  assign st_clr  = (wr_hit && widx == A_CLR)    ? reg_wdata[ST_W-1:0]  : '0;
  assign err_clr = (wr_hit && widx == A_ERRCLR) ? reg_wdata[ERR_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      err_q  <= '0;
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      st_q  <= (st_q & ~st_clr) | st_set;
      err_q <= (err_q & ~err_clr) | err_evt;
      if (wr_hit && widx == A_ENA) en_a_q <= reg_wdata[ST_W-1:0];
      if (wr_hit && widx == A_ENB) en_b_q <= reg_wdata[ST_W-1:0];
    end
  end

  assign irq_a = |(st_q & en_a_q);
  assign irq_b = |(st_q & en_b_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr) begin
      for (int i = 0; i < MSG_WORDS; i++)
        if (widx == WI_W'(i)) reg_rdata = msg_q[i];
      for (int i = 0; i < FAST_CH; i++)
        if (widx == WI_W'(W_FAST + i)) reg_rdata = fast_q[i];
      if (widx == A_ERR)  reg_rdata = 32'(err_q);
      if (widx == A_ENA)  reg_rdata = 32'(en_a_q);
      if (widx == A_ENB)  reg_rdata = 32'(en_b_q);
      if (widx == A_STAT) reg_rdata = 32'(st_q);
    end
  end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int MSG_WORDS = 32,
  parameter int FAST_CH   = 8,
  parameter int ADDR_W    = 8,
  localparam int ST_W     = 9 + FAST_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [6:0]        fifo_evt,
  input logic [ST_W-1:0]   st,
  input logic              irq_a,
  input logic              irq_b
);
  localparam int W_TRIG = MSG_WORDS;
  localparam int W_FAST = MSG_WORDS + 3;
  localparam int W_ENA  = W_FAST + FAST_CH + 4;
  localparam int W_ENB  = W_ENA + 1;
  localparam int W_CLR  = W_ENA + 2;
  localparam int W_STAT = W_ENA + 3;

  int unsigned w;
  logic wr, rd;
  assign w  = int'(reg_addr) >> 2;
  assign wr = reg_sel && reg_wr;
  assign rd = reg_sel && !reg_wr;

  assert_doorbell_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_TRIG && reg_wdata[0] |=> st[0]);
  assert_trig_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd && w == W_TRIG |-> reg_rdata == 32'd0);
  assert_fast_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_FAST |=> st[9]);
  assert_fast_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_FAST + FAST_CH - 1 |=> st[ST_W-1]);
  assert_clear_doorbell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_CLR && reg_wdata[0] |=> !st[0]);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_evt[0] |=> st[2]);
  assert_irq_b_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_ENB && reg_wdata == 32'd0 |=> !irq_b);
  assert_irq_a_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_ENA && reg_wdata[0] && st[0] |=> irq_a);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd && w > W_STAT |-> reg_rdata == 32'd0);
  assert_status_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr && w == W_STAT && fifo_evt == 7'd0 |=> st == $past(st));
endmodule

bind mbox_bank mbox_bank_chk #(.MSG_WORDS(MSG_WORDS), .FAST_CH(FAST_CH), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_evt(fifo_evt), .st(st_q),
  .irq_a(irq_a), .irq_b(irq_b));

// File: tb/mbox_bank_test.sv
module mbox_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NMSG = 32, NF = 8, EW = 16, AW = 8, SW = 17;

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [6:0] fifo_evt = '0;
  logic [EW-1:0] err_evt = '0;
  logic irq_a, irq_b;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  mbox_bank #(.MSG_WORDS(NMSG), .FAST_CH(NF), .ERR_W(EW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_evt(fifo_evt), .err_evt(err_evt),
    .irq_a(irq_a), .irq_b(irq_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] mm [NMSG];
  logic [31:0] mf [NF];
  logic [SW-1:0] ms, mea, meb;
  logic [EW-1:0] me;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 0;
      foreach (mf[i]) mf[i] = 0;
      ms = 0; mea = 0; meb = 0; me = 0;
    end else begin
      int w;
      logic [SW-1:0] s, c;
      logic [EW-1:0] ec;
      w = int'(reg_addr) / 4;
      s = '0; c = '0; ec = '0;
      for (int k = 0; k < 7; k++) if (fifo_evt[k]) s[2+k] = 1;
      if (reg_sel && reg_wr) begin
        if (w < NMSG) mm[w] = reg_wdata;
        else if (w == 32) begin s[0] = s[0] | reg_wdata[0]; s[1] = s[1] | reg_wdata[1]; end
        else if (w == 34) ec = reg_wdata[EW-1:0];
        else if (w >= 35 && w < 35 + NF) begin mf[w-35] = reg_wdata; s[9+w-35] = 1; end
        else if (w == 47) mea = reg_wdata[SW-1:0];
        else if (w == 48) meb = reg_wdata[SW-1:0];
        else if (w == 49) c = reg_wdata[SW-1:0];
      end
      ms = (ms & ~c) | s;
      me = (me & ~ec) | err_evt;
    end
  end

  function automatic logic [31:0] model_rd(int w);
    if (w < NMSG) return mm[w];
    if (w == 33) return 32'(me);
    if (w >= 35 && w < 35 + NF) return mf[w-35];
    if (w == 47) return 32'(mea);
    if (w == 48) return 32'(meb);
    if (w == 50) return 32'(ms);
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: interrupt lines compared against the model on every clock
  always @(negedge clk) if (rst_n && !done) begin
    check("R8 irq_a", 32'(irq_a), 32'(|(ms & mea)));
    check("R8 irq_b", 32'(irq_b), 32'(|(ms & meb)));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    reg_sel = 1; reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); #1;
    reg_sel = 0; reg_wr = 0; fifo_evt = 0; err_evt = 0;
  endtask

  task automatic rd(string req, int a);
    @(negedge clk); #1;
    reg_sel = 1; reg_wr = 0; reg_addr = AW'(a);
    #1 check(req, reg_rdata, model_rd(a / 4));
    @(negedge clk); #1 reg_sel = 0;
  endtask

  task automatic rd_exp(string req, int a, logic [31:0] e);
    @(negedge clk); #1;
    reg_sel = 1; reg_wr = 0; reg_addr = AW'(a);
    #1 check(req, reg_rdata, e);
    @(negedge clk); #1 reg_sel = 0;
  endtask

  task automatic pulse(logic [6:0] f, logic [EW-1:0] e);
    @(negedge clk); #1;
    fifo_evt = f; err_evt = e;
    @(negedge clk); #1;
    fifo_evt = 0; err_evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_exp("R1 status", 'hC8, 0);
    rd_exp("R1 enable A", 'hBC, 0);
    rd_exp("R1 msg0", 'h00, 0);
    rd_exp("R1 msg31", 'h7C, 0);
    rd_exp("R1 fast7", 'hA8, 0);
    rd_exp("R1 error", 'h84, 0);
    // R2 message words
    wr('h00, 32'hDEAD_BEEF); wr('h14, 32'h1234_5678); wr('h7C, 32'hA5A5_0F0F);
    rd_exp("R2 msg0", 'h00, 32'hDEAD_BEEF);
    rd_exp("R2 msg5", 'h14, 32'h1234_5678);
    rd_exp("R2 msg31", 'h7C, 32'hA5A5_0F0F);
    for (int i = 0; i < NMSG; i++) rd("R2 sweep", 4*i);
    // R3 trigger
    wr('h80, 32'h1);
    rd_exp("R3 doorbell", 'hC8, 32'h1);
    wr('h80, 32'h2);
    rd_exp("R3 ack", 'hC8, 32'h3);
    rd_exp("R3 trigger reads zero", 'h80, 0);
    // R5 clear
    wr('hC4, 32'h1);
    rd_exp("R5 clear bit0", 'hC8, 32'h2);
    wr('hC4, 32'h0);
    rd_exp("R5 zeros unchanged", 'hC8, 32'h2);
    wr('hC4, 32'h2);
    rd_exp("R5 clear bit1", 'hC8, 32'h0);
    // R4 fast channels
    wr('h8C, 32'h0000_00C0);
    wr('hA8, 32'hFACE_0007);
    rd_exp("R4 fast0 data", 'h8C, 32'h0000_00C0);
    rd_exp("R4 fast7 data", 'hA8, 32'hFACE_0007);
    rd_exp("R4 fast status", 'hC8, 32'h0001_0200);
    for (int n = 1; n < 7; n++) wr('h8C + 4*n, 32'(n));
    rd_exp("R4 all fast status", 'hC8, 32'h0001_FE00);
    wr('hC4, 32'h0001_FE00);
    // R7 fifo events
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k), '0);
      rd_exp("R7 fifo event bit", 'hC8, 32'(1) << (2+k));
      wr('hC4, 32'(1) << (2+k));
    end
    // R8 masks
    wr('hBC, 32'h0001_FFFF);
    rd_exp("R8 enable A readback", 'hBC, 32'h0001_FFFF);
    wr('hC0, 32'h0000_0100);
    rd_exp("R8 enable B readback", 'hC0, 32'h0000_0100);
    wr('h80, 32'h1);
    @(negedge clk); check("R8 irq_a from doorbell", 32'(irq_a), 1);
    check("R8 irq_b masked", 32'(irq_b), 0);
    pulse(7'h40, '0);
    @(negedge clk); check("R8 irq_b from non-empty", 32'(irq_b), 1);
    wr('hC0, 0);
    @(negedge clk); check("R8 irq_b disabled", 32'(irq_b), 0);
    wr('hC4, 32'h0001_FFFF);
    @(negedge clk); check("R8 irq_a cleared", 32'(irq_a), 0);
    // R6 set wins over clear
    @(negedge clk); #1;
    reg_sel = 1; reg_wr = 1; reg_addr = 'hC4; reg_wdata = 32'h4; fifo_evt = 7'h1;
    @(negedge clk); #1;
    reg_sel = 0; reg_wr = 0; fifo_evt = 0;
    rd_exp("R6 status set wins", 'hC8, 32'h4);
    @(negedge clk); #1;
    reg_sel = 1; reg_wr = 1; reg_addr = 'h88; reg_wdata = 32'h8; err_evt = 16'h8;
    @(negedge clk); #1;
    reg_sel = 0; reg_wr = 0; err_evt = 0;
    rd_exp("R6 error set wins", 'h84, 32'h8);
    // R9 error pair
    pulse('0, 16'h8001);
    rd_exp("R9 error sticky", 'h84, 32'h8009);
    wr('h84, 32'hFFFF_FFFF);
    rd_exp("R9 error ignores write", 'h84, 32'h8009);
    wr('h88, 32'h0000_0001);
    rd_exp("R9 error clear", 'h84, 32'h8008);
    rd_exp("R9 clear reads zero", 'h88, 0);
    // R10 unmapped and read-only status
    wr('hAC, 32'hFFFF_FFFF); wr('hCC, 32'hFFFF_FFFF); wr('hFC, 32'hFFFF_FFFF);
    rd_exp("R10 gap read", 'hAC, 0);
    rd_exp("R10 high read", 'hCC, 0);
    rd_exp("R10 top read", 'hFC, 0);
    wr('hC8, 32'hFFFF_FFFF);
    rd_exp("R10 status read-only", 'hC8, 32'h4);
    for (int a = 0; a < 256; a += 4) rd("R10 full map sweep", a);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule